// File: doc/BRIEF.md
# External Interrupt Aggregator with APB Register Port

This block gathers a set of active-high level interrupt lines from the rest of the chip and turns them into one interrupt request for a platform-level interrupt controller. Each line has a bit position that is the same in every register. A line that goes high is brought across by a two-flop synchronizer and latched as pending. The pending bit stays set until software clears it, even if the line has since dropped.

Software reaches the block through an APB slave port. A mask register decides which pending bits can reach the status view and the combined request. A mask bit of 1 blocks its source. A clear register removes pending state with a pulse: software writes the bit to 1, then writes it back to 0. While the clear bit is 1 the pending bit is held at zero. Once the clear bit is 0 again, a line that is still high sets the pending bit once more. The usual handler reads status, services each set bit, and clears it with that two-write pulse.

Top module: `ext_irq_aggregator`

## Requirements
- R1: After reset the mask register reads all ones for the implemented sources, the clear register reads 0, the status register reads 0 and `irq_out` is low.
- R2: The clear register (offset 0x10) and the mask register (offset 0x14) read back the last value written to them, one bit per source, with bit i belonging to source i.
- R3: A high level on source i sets pending bit i. The bit stays set after the line returns low, and it falls only when clear bit i is 1.
- R4: The status register (offset 0x1C) reads pending AND NOT mask. A mask bit of 1 hides its source and a mask bit of 0 shows it.
- R5: While clear bit i is 1, pending bit i stays 0 even if source i is high. After clear bit i returns to 0, a source that is still high sets the pending bit again.
- R6: `irq_out` is high exactly when the status register is nonzero.
- R7: Writes to the status register have no effect. Reads of any offset other than 0x10, 0x14 and 0x1C return 0. Every transfer completes with `pready` high and `pslverr` low.
- R8: A source input goes through two synchronizer flops. A rise that is sampled at clock edge k shows in status after edge k+2 and not before it.
- R9: Clearing one set of bits leaves the pending state of every other source unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | APB clock; clocks all state |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid during a selected cycle |
| pready | output | 1 | Always high; no wait states |
| pslverr | output | 1 | Always low |
| src_in | input | NUM_SRC | Active-high asynchronous interrupt lines |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The hardest case to reach is a clear pulse that lands while its source is still high. The pending bit must stay at zero for the whole time the clear bit is 1, and it must come back on its own after the release. The bench holds a line high through the whole clear pulse and reads status both during the pulse and after it. A second case is the two-edge synchronizer latency. To see it, the bench holds the APB setup phase on the status offset, so `prdata` can be sampled after each single clock edge without starting a transfer. A sweep over every source position, and a sweep of mask patterns against full pending state, cover the bit-to-source mapping.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int unsigned DATA_W = 32;

    // Register offsets in the byte address space of the slave.
    localparam logic [7:0] OFS_CLEAR  = 8'h10;
    localparam logic [7:0] OFS_MASK   = 8'h14;
    localparam logic [7:0] OFS_STATUS = 8'h1C;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_CLEAR  = 2'd1,
        SEL_MASK   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
    parameter int unsigned N      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_in,
    output logic [N-1:0] sync_out
);

    logic [N-1:0] stage_d [STAGES];
    logic [N-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stage_d[s] = async_in;
        end else begin : g_next
            always_comb stage_d[s] = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/irq_agg_pend.sv
module irq_agg_pend #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level_in,
    input  logic [N-1:0] clear_hold,
    input  logic [N-1:0] block,
    output logic [N-1:0] pend,
    output logic [N-1:0] visible,
    output logic         any_visible
);

    typedef struct packed {
        logic [N-1:0] pend;
    } pend_state_t;

    pend_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (clear_hold[i]) begin
                st_d.pend[i] = 1'b0;           // clear beats set
            end else if (level_in[i]) begin
                st_d.pend[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend        = st_q.pend;
    assign visible     = st_q.pend & ~block;
    assign any_visible = |visible;

endmodule

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
    import irq_agg_pkg::*;
#(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [N-1:0]      status,
    output logic [DATA_W-1:0] prdata,
    output logic [N-1:0]      clear_q,
    output logic [N-1:0]      mask_q
);

    typedef struct packed {
        logic [N-1:0] clr;
        logic [N-1:0] mask;
    } reg_state_t;

    reg_state_t st_d, st_q;
    reg_sel_e   sel;
    logic       wr_en;

    always_comb begin
        sel = SEL_NONE;
        if (paddr == ADDR_W'(OFS_CLEAR)) begin
            sel = SEL_CLEAR;
        end else if (paddr == ADDR_W'(OFS_MASK)) begin
            sel = SEL_MASK;
        end else if (paddr == ADDR_W'(OFS_STATUS)) begin
            sel = SEL_STATUS;
        end
    end

    assign wr_en = psel & penable & pwrite;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_CLEAR: st_d.clr  = pwdata[N-1:0];
                SEL_MASK:  st_d.mask = pwdata[N-1:0];
                default:   ;                  // status and holes ignore writes
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.clr  <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        prdata = '0;
        if (psel) begin
            case (sel)
                SEL_CLEAR:  prdata = DATA_W'(st_q.clr);
                SEL_MASK:   prdata = DATA_W'(st_q.mask);
                SEL_STATUS: prdata = DATA_W'(status);
                default:    prdata = '0;
            endcase
        end
    end

    assign clear_q = st_q.clr;
    assign mask_q  = st_q.mask;

endmodule

// File: rtl/ext_irq_aggregator.sv
module ext_irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int unsigned NUM_SRC     = 32,
    parameter int unsigned ADDR_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic [NUM_SRC-1:0] src_in,
    output logic              irq_out
);

    logic [NUM_SRC-1:0] sync_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] clr_q;
    logic [NUM_SRC-1:0] status;

    irq_agg_sync #(
        .N      (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (pclk),
        .rst_n    (presetn),
        .async_in (src_in),
        .sync_out (sync_q)
    );

    irq_agg_pend #(
        .N (NUM_SRC)
    ) u_pend (
        .clk         (pclk),
        .rst_n       (presetn),
        .level_in    (sync_q),
        .clear_hold  (clr_q),
        .block       (mask_q),
        .pend        (pend_q),
        .visible     (status),
        .any_visible (irq_out)
    );

    irq_agg_regs #(
        .N      (NUM_SRC),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .status  (status),
        .prdata  (prdata),
        .clear_q (clr_q),
        .mask_q  (mask_q)
    );

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
    parameter int unsigned N = 32
) (
    input logic         pclk,
    input logic         presetn,
    input logic         pready,
    input logic         pslverr,
    input logic         irq_out,
    input logic [N-1:0] sync_q,
    input logic [N-1:0] pend_q,
    input logic [N-1:0] mask_q,
    input logic [N-1:0] clr_q
);

    AST_CLEAR_FORCES_ZERO: assert property (@(posedge pclk) disable iff (!presetn)
        (pend_q & $past(clr_q)) == '0);                                     // R5

    AST_PEND_NEEDS_LEVEL: assert property (@(posedge pclk) disable iff (!presetn)
        (pend_q & ~$past(pend_q) & ~$past(sync_q)) == '0);                  // R8

    AST_PEND_STICKY: assert property (@(posedge pclk) disable iff (!presetn)
        ($past(pend_q) & ~$past(clr_q) & ~pend_q) == '0);                   // R3

    AST_APB_NO_ERROR: assert property (@(posedge pclk) disable iff (!presetn)
        pready && !pslverr);                                                // R7

    AST_FULL_MASK_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
        (&mask_q) |-> !irq_out);                                            // R6

endmodule

bind ext_irq_aggregator irq_agg_chk #(.N(NUM_SRC)) u_chk (
    .pclk    (pclk),
    .presetn (presetn),
    .pready  (pready),
    .pslverr (pslverr),
    .irq_out (irq_out),
    .sync_q  (sync_q),
    .pend_q  (pend_q),
    .mask_q  (mask_q),
    .clr_q   (clr_q)
);

// File: tb/ext_irq_aggregator_tb.sv
module ext_irq_aggregator_tb;

    localparam int N  = 32;
    localparam int AW = 16;
    localparam logic [AW-1:0] A_CLR  = 16'h0010;
    localparam logic [AW-1:0] A_MASK = 16'h0014;
    localparam logic [AW-1:0] A_STAT = 16'h001C;

    logic          pclk = 1'b0;
    logic          presetn = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr, irq_out;
    logic [N-1:0]  src_in = '0;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 pclk = ~pclk;

    ext_irq_aggregator #(.NUM_SRC(N), .ADDR_W(AW)) u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .src_in(src_in), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge pclk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge pclk);
        penable = 1;
        #1;
        d = prdata;
        if (!pready || pslverr) check("R7 handshake", {30'd0, pready, pslverr}, 32'h2);
        @(negedge pclk);
        psel = 0; penable = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge pclk);
            cyc++;
            if (cyc > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] pats [6];
        pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'hA5A5_5A5A;
        pats[3] = 32'h0F0F_F0F0; pats[4] = 32'h8000_0001; pats[5] = 32'h1234_5678;

        idle(5);
        presetn = 1;
        idle(2);

        // R1 reset state
        rd(A_MASK, v); check("R1 mask reset", v, 32'hFFFF_FFFF);
        rd(A_CLR, v);  check("R1 clear reset", v, 32'h0);
        rd(A_STAT, v); check("R1 status reset", v, 32'h0);
        check("R1 irq reset", {31'd0, irq_out}, 32'h0);

        // R2 readback of clear and mask
        for (int p = 0; p < 6; p++) begin
            wr(A_MASK, pats[p]); rd(A_MASK, v); check("R2 mask readback", v, pats[p]);
            wr(A_CLR, pats[p]);  rd(A_CLR, v);  check("R2 clear readback", v, pats[p]);
        end
        wr(A_CLR, 32'h0);
        wr(A_MASK, 32'h0);

        // R3, R5, R6 sweep over every source position
        for (int i = 0; i < N; i++) begin
            src_in = 32'h1 << i;
            idle(4);
            rd(A_STAT, v); check("R3 pending sets", v, 32'h1 << i);
            check("R6 irq with pending", {31'd0, irq_out}, 32'h1);
            src_in = '0;
            idle(4);
            rd(A_STAT, v); check("R3 pending sticky", v, 32'h1 << i);
            wr(A_CLR, 32'h1 << i);
            rd(A_STAT, v); check("R5 cleared", v, 32'h0);
            wr(A_CLR, 32'h0);
            rd(A_STAT, v); check("R5 stays clear after release", v, 32'h0);
            check("R6 irq low when empty", {31'd0, irq_out}, 32'h0);
        end

        // R4 mask patterns against full pending
        src_in = '1;
        idle(4);
        src_in = '0;
        for (int p = 0; p < 6; p++) begin
            wr(A_MASK, pats[p]);
            rd(A_STAT, v); check("R4 status masked", v, ~pats[p]);
            check("R6 irq vs status", {31'd0, irq_out}, {31'd0, (~pats[p]) != 0});
        end
        wr(A_MASK, 32'h0);

        // R7 status writes ignored, holes read zero
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); check("R7 status write ignored", v, 32'hFFFF_FFFF);
        for (int a = 0; a < 64; a += 4) begin
            if (a != 'h10 && a != 'h14 && a != 'h1C) begin
                wr(AW'(a), 32'hDEAD_BEEF);
                rd(AW'(a), v); check("R7 hole reads zero", v, 32'h0);
            end
        end
        rd(A_MASK, v); check("R7 hole write no effect on mask", v, 32'h0);

        // R9 partial clear
        wr(A_CLR, 32'h0000_FFFF);
        wr(A_CLR, 32'h0);
        rd(A_STAT, v); check("R9 other bits kept", v, 32'hFFFF_0000);
        wr(A_CLR, 32'hFFFF_FFFF);
        wr(A_CLR, 32'h0);

        // R5 clear pulse while source still high
        src_in = 32'h0000_0100;
        idle(4);
        wr(A_CLR, 32'h0000_0100);
        idle(3);
        rd(A_STAT, v); check("R5 held at zero under clear", v, 32'h0);
        rd(A_STAT, v); check("R5 held at zero under clear again", v, 32'h0);
        wr(A_CLR, 32'h0);
        idle(2);
        rd(A_STAT, v); check("R5 re-sets after release", v, 32'h0000_0100);
        src_in = '0;
        wr(A_CLR, 32'hFFFF_FFFF);
        wr(A_CLR, 32'h0);

        // R8 synchronizer latency, observed in a held setup phase
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = 0; paddr = A_STAT;
        #0.5;
        check("R8 before edges", prdata, 32'h0);
        src_in = 32'h0000_0004;
        @(negedge pclk); #0.5; check("R8 after one edge", prdata, 32'h0);
        @(negedge pclk); #0.5; check("R8 after two edges", prdata, 32'h0);
        @(negedge pclk); #0.5; check("R8 after three edges", prdata, 32'h0000_0004);
        psel = 0;
        src_in = '0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule